// File: doc/BRIEF.md
# Complex Phase Derotator with Committed Coefficient

This block removes a carrier phase offset from a stream of complex baseband samples. Each sample A + iB is multiplied by the conjugate of a phase reference C + iD. The result is (A·C + B·D) + i(B·C − A·D). The product is rounded and saturated back to the sample width and handed downstream. Any conversion to a serial bit stream happens there, after the rotation.

The phase reference changes slowly. An external controller estimates it and writes it into the block. The block holds it constant until the next update. Writes land in a shadow pair and become active only on a separate commit strobe, so the cosine and sine terms always switch together, on a sample boundary. After reset the active reference is 1.0 + i0, so samples pass through unchanged.

Top module: `cplx_derotator`

## Requirements
- R1: While reset is asserted and at the first clock edge after its release, `out_valid`, `out_re` and `out_im` are all zero.
- R2: The real output equals (A·C + B·D) scaled by 2^-14, rounded and saturated. A and B are signed sample integers; C and D are signed Q1.14, so 0x4000 = 1.0.
- R3: The imaginary output equals (B·C − A·D) scaled by 2^-14, rounded and saturated.
- R4: Rounding adds 2^13 to the full-precision sum and then floors it (halves round toward positive infinity). For example, with C = 0x2000 and D = 0, A = −1 gives 0, A = 3 gives 2 and A = −3 gives −1.
- R5: A result outside [−2^15, 2^15−1] is clamped to the nearest limit.
- R6: Each sample accepted with `in_valid` high appears at the outputs exactly 3 clock edges later, with `out_valid` high. `out_valid` is low in every other cycle.
- R7: `out_re` and `out_im` hold their previous values in every cycle where `out_valid` is low.
- R8: Coefficient writes without a commit do not change the rotation applied to samples.
- R9: A commit strobe copies the shadow pair to the active pair at that clock edge. A sample accepted on the same edge still uses the old pair, and the first sample accepted after that edge uses the new one.
- R10: After reset the active pair is C = 0x4000, D = 0, so every sample passes through unchanged.
- R11: `coef_wr_sel` = 0 writes C and = 1 writes D into the shadow pair. When a write and a commit occur in the same cycle, the commit takes the shadow value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| coef_wr_en | input | 1 | Write strobe for the shadow coefficient pair |
| coef_wr_sel | input | 1 | Shadow target: 0 = cosine term C, 1 = sine term D |
| coef_wr_data | input | COEF_W (16) | Signed Q1.14 coefficient value |
| coef_commit | input | 1 | Copies the shadow pair into the active pair |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | DATA_W (16) | Input real part A, signed |
| in_im | input | DATA_W (16) | Input imaginary part B, signed |
| out_valid | output | 1 | Output sample strobe |
| out_re | output | DATA_W (16) | Derotated real part, signed |
| out_im | output | DATA_W (16) | Derotated imaginary part, signed |

## Verification
The latency and hold assertions assume that `in_valid` is a clean 0/1 level sampled once per cycle. They also assume the controller never expects an active-pair change without a commit. The coefficient assertions assume that write, select and commit are stable around the clock edge. The stimulus drives every input one time unit after a rising edge and holds it for the full cycle. It keeps coefficient values within the 16-bit signed range. It issues commits only as single-cycle pulses, including one that coincides with a sample and one that coincides with a write.

// File: rtl/derot_pkg.sv
package derot_pkg;
  // Fraction bits of the coefficient format (Q1.14).
  localparam int unsigned COEF_FRAC_DEF = 14;

  // Shadow register selector.
  typedef enum logic {
    SEL_COS = 1'b0,
    SEL_SIN = 1'b1
  } coef_sel_e;
endpackage

// File: rtl/derot_coef_bank.sv
// Shadow/active coefficient pair. Writes hit the shadow; commit moves both at once.
module derot_coef_bank
  import derot_pkg::*;
#(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC   = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic signed [COEF_W-1:0] wr_data,
  input  logic                     commit,
  output logic signed [COEF_W-1:0] shadow_c,
  output logic signed [COEF_W-1:0] shadow_d,
  output logic signed [COEF_W-1:0] act_c,
  output logic signed [COEF_W-1:0] act_d
);
  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC;

  logic signed [COEF_W-1:0] shadow_c_d, shadow_d_d, act_c_d, act_d_d;

  always_comb begin
    shadow_c_d = shadow_c;
    shadow_d_d = shadow_d;
    act_c_d    = act_c;
    act_d_d    = act_d;
    if (wr_en) begin
      if (coef_sel_e'(wr_sel) == SEL_COS) shadow_c_d = wr_data;
      else                                shadow_d_d = wr_data;
    end
    if (commit) begin
      act_c_d = shadow_c;
      act_d_d = shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_c <= UNITY;
      shadow_d <= '0;
      act_c    <= UNITY;
      act_d    <= '0;
    end else begin
      shadow_c <= shadow_c_d;
      shadow_d <= shadow_d_d;
      act_c    <= act_c_d;
      act_d    <= act_d_d;
    end
  end
endmodule

// File: rtl/derot_mult_stage.sv
// Stage 1 captures sample and active pair; stage 2 registers the four products.
module derot_mult_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  localparam int unsigned PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_a,
  input  logic signed [DATA_W-1:0] in_b,
  input  logic signed [COEF_W-1:0] coef_c,
  input  logic signed [COEF_W-1:0] coef_d,
  output logic                     prod_valid,
  output logic signed [PROD_W-1:0] prod [4]
);
  localparam int unsigned NPROD = 4;

  logic                     s1_valid;
  logic signed [DATA_W-1:0] s1_a, s1_b;
  logic signed [COEF_W-1:0] s1_c, s1_d;

  logic signed [DATA_W-1:0] op_x [NPROD];
  logic signed [COEF_W-1:0] op_y [NPROD];
  logic signed [PROD_W-1:0] prod_d [NPROD];

  // Stage 1 registers, loaded only on an accepted sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_c     <= '0;
      s1_d     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_a <= in_a;
        s1_b <= in_b;
        s1_c <= coef_c;
        s1_d <= coef_d;
      end
    end
  end

  // Product order: 0 = A*C, 1 = B*D, 2 = B*C, 3 = A*D.
  always_comb begin
    op_x[0] = s1_a; op_y[0] = s1_c;
    op_x[1] = s1_b; op_y[1] = s1_d;
    op_x[2] = s1_b; op_y[2] = s1_c;
    op_x[3] = s1_a; op_y[3] = s1_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_valid <= 1'b0;
    else        prod_valid <= s1_valid;
  end

  for (genvar k = 0; k < NPROD; k++) begin : g_mul
    always_comb prod_d[k] = PROD_W'(op_x[k]) * PROD_W'(op_y[k]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prod[k] <= '0;
      else if (s1_valid) prod[k] <= prod_d[k];
    end
  end
endmodule

// File: rtl/derot_round_sat.sv
// Round half up by FRAC bits, then clamp to OUT_W signed.
module derot_round_sat #(
  parameter int unsigned IN_W  = 33,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned FRAC  = 14
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int unsigned EXT_W = IN_W + 1;
  localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) << (FRAC - 1);
  localparam logic signed [EXT_W-1:0] MAXV = (EXT_W'(1) << (OUT_W - 1)) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] MINV = ~MAXV;

  logic signed [EXT_W-1:0] biased, shifted;

  always_comb begin
    biased  = EXT_W'(din) + HALF;
    shifted = biased >>> FRAC;
    if (shifted > MAXV)      dout = {1'b0, {(OUT_W-1){1'b1}}};
    else if (shifted < MINV) dout = {1'b1, {(OUT_W-1){1'b0}}};
    else                     dout = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/cplx_derotator.sv
// Conjugate-multiply derotator, 3-cycle latency.
module cplx_derotator
  import derot_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     coef_wr_en,
  input  logic                     coef_wr_sel,
  input  logic signed [COEF_W-1:0] coef_wr_data,
  input  logic                     coef_commit,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im
);
  localparam int unsigned FRAC   = COEF_FRAC_DEF;
  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam int unsigned SUM_W  = PROD_W + 1;
  localparam int unsigned NLANE  = 2;

  logic signed [COEF_W-1:0] shadow_c, shadow_d, act_c, act_d;
  logic                     prod_valid;
  logic signed [PROD_W-1:0] prod [4];
  logic signed [SUM_W-1:0]  lane_sum [NLANE];
  logic signed [DATA_W-1:0] lane_q   [NLANE];
  logic signed [DATA_W-1:0] out_re_d, out_im_d;

  derot_coef_bank #(.COEF_W(COEF_W), .FRAC(FRAC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (coef_wr_en),
    .wr_sel   (coef_wr_sel),
    .wr_data  (coef_wr_data),
    .commit   (coef_commit),
    .shadow_c (shadow_c),
    .shadow_d (shadow_d),
    .act_c    (act_c),
    .act_d    (act_d)
  );

  derot_mult_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mult (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_a       (in_re),
    .in_b       (in_im),
    .coef_c     (act_c),
    .coef_d     (act_d),
    .prod_valid (prod_valid),
    .prod       (prod)
  );

  // Lane 0: A*C + B*D, lane 1: B*C - A*D.
  always_comb begin
    lane_sum[0] = SUM_W'(prod[0]) + SUM_W'(prod[1]);
    lane_sum[1] = SUM_W'(prod[2]) - SUM_W'(prod[3]);
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    derot_round_sat #(.IN_W(SUM_W), .OUT_W(DATA_W), .FRAC(FRAC)) u_rs (
      .din  (lane_sum[l]),
      .dout (lane_q[l])
    );
  end

  always_comb begin
    out_re_d = prod_valid ? lane_q[0] : out_re;
    out_im_d = prod_valid ? lane_q[1] : out_im;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= prod_valid;
      out_re    <= out_re_d;
      out_im    <= out_im_d;
    end
  end
endmodule

// File: rtl/derot_checker.sv
module derot_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     coef_wr_en,
  input logic                     coef_wr_sel,
  input logic signed [COEF_W-1:0] coef_wr_data,
  input logic                     coef_commit,
  input logic signed [COEF_W-1:0] shadow_c,
  input logic signed [COEF_W-1:0] shadow_d,
  input logic signed [COEF_W-1:0] act_c,
  input logic signed [COEF_W-1:0] act_d,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_re,
  input logic signed [DATA_W-1:0] out_im
);
  // Edges seen since reset release, saturating at 3.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (!out_valid && out_re == '0 && out_im == '0));

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !out_valid) |-> ($stable(out_re) && $stable(out_im)));

  a_r8_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !$past(coef_commit)) |-> ($stable(act_c) && $stable(act_d)));

  a_r9_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(coef_commit)) |->
      (act_c == $past(shadow_c) && act_d == $past(shadow_d)));

  a_r11_write_cos: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(coef_wr_en) && !$past(coef_wr_sel)) |->
      (shadow_c == $past(coef_wr_data)));

  a_r11_write_sin: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(coef_wr_en) && $past(coef_wr_sel)) |->
      (shadow_d == $past(coef_wr_data)));
endmodule

bind cplx_derotator derot_checker #(.DATA_W(DATA_W), .COEF_W(COEF_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .coef_wr_en   (coef_wr_en),
  .coef_wr_sel  (coef_wr_sel),
  .coef_wr_data (coef_wr_data),
  .coef_commit  (coef_commit),
  .shadow_c     (shadow_c),
  .shadow_d     (shadow_d),
  .act_c        (act_c),
  .act_d        (act_d),
  .out_valid    (out_valid),
  .out_re       (out_re),
  .out_im       (out_im)
);

// File: tb/cplx_derotator_tb_top.sv
module cplx_derotator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic coef_wr_en, coef_wr_sel, coef_commit, in_valid;
  logic signed [CW-1:0] coef_wr_data;
  logic signed [DW-1:0] in_re, in_im;
  logic out_valid;
  logic signed [DW-1:0] out_re, out_im;

  always #(CLK_PERIOD/2) clk = ~clk;

  cplx_derotator #(.DATA_W(DW), .COEF_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .coef_wr_en(coef_wr_en), .coef_wr_sel(coef_wr_sel),
    .coef_wr_data(coef_wr_data), .coef_commit(coef_commit),
    .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit rv [8];
  int rre [8];
  int rim [8];
  string rtag [8];
  int m_sc = 16384, m_sd = 0, m_ac = 16384, m_ad = 0;
  int last_re = 0, last_im = 0;

  function automatic int sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int rnd(longint p);
    return sat((p + 64'sd8192) >>> 14);
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  // One clock: check the output due now, then drive the next inputs.
  task automatic step(bit v, int a, int b, bit we, bit sel, int wd, bit cm, string tag);
    int s;
    @(posedge clk); #1;
    cyc++;
    s = (cyc + 5) % 8;
    check("R6", "out_valid", int'(out_valid), int'(rv[s]));
    if (rv[s]) begin
      check(rtag[s], "out_re", int'(out_re), rre[s]);
      check(rtag[s], "out_im", int'(out_im), rim[s]);
      last_re = rre[s];
      last_im = rim[s];
    end else begin
      check("R7", "held out_re", int'(out_re), last_re);
      check("R7", "held out_im", int'(out_im), last_im);
    end
    in_valid = v; in_re = DW'(a); in_im = DW'(b);
    coef_wr_en = we; coef_wr_sel = sel; coef_wr_data = CW'(wd); coef_commit = cm;
    s = cyc % 8;
    rv[s] = v;
    rtag[s] = tag;
    rre[s] = rnd(longint'(a) * m_ac + longint'(b) * m_ad);
    rim[s] = rnd(longint'(b) * m_ac - longint'(a) * m_ad);
    if (cm) begin m_ac = m_sc; m_ad = m_sd; end
    if (we) begin if (sel) m_sd = wd; else m_sc = wd; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  task automatic load(int c, int d);
    step(0, 0, 0, 1, 0, c, 0, "R11");
    step(0, 0, 0, 1, 1, d, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 1, "R9");
  endtask

  int vals [9] = '{-32768, -32767, -12345, -3, -1, 0, 1, 3, 32767};
  int cset [7] = '{11585, 0, -16384, 32767, -32768, 16384, -11585};
  int dset [7] = '{11585, 16384, 0, 32767, -32768, 16384, 23170};

  initial begin
    for (int i = 0; i < 8; i++) begin rv[i] = 0; rre[i] = 0; rim[i] = 0; rtag[i] = "idle"; end
    rst_n = 1'b0;
    in_valid = 0; in_re = '0; in_im = '0;
    coef_wr_en = 0; coef_wr_sel = 0; coef_wr_data = '0; coef_commit = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "out_re in reset", int'(out_re), 0);
    check("R1", "out_im in reset", int'(out_im), 0);
    @(negedge clk) rst_n = 1'b1;

    // R10: default pair is unity, samples pass unchanged.
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++) step(1, vals[i], vals[j], 0, 0, 0, 0, "R10");
    idle(4);

    // R8: shadow writes without commit change nothing; gaps exercise R7.
    step(0, 0, 0, 1, 0, 8192, 0, "R8");
    step(0, 0, 0, 1, 1, 4096, 0, "R8");
    for (int i = 0; i < 9; i++) begin
      step(1, vals[i], vals[8 - i], 0, 0, 0, 0, "R8");
      idle(2);
    end
    check("R8", "model pair untouched", m_ac, 16384);
    idle(4);

    // R9: commit coincides with a sample (old pair), next sample uses new pair.
    step(1, 1000, 2000, 0, 0, 0, 1, "R9");
    step(1, 1000, 2000, 0, 0, 0, 0, "R9");
    step(1, -1000, 300, 0, 0, 0, 0, "R9");
    idle(4);

    // R4: half-way rounding with C = 0.5, D = 0.
    load(8192, 0);
    step(1, 1, 0, 0, 0, 0, 0, "R4");
    step(1, -1, 0, 0, 0, 0, 0, "R4");
    step(1, 3, 0, 0, 0, 0, 0, "R4");
    step(1, -3, 0, 0, 0, 0, 0, "R4");
    step(1, 0, -3, 0, 0, 0, 0, "R4");
    idle(4);
    check("R4", "half of -1 rounds up", rnd(-64'sd8192), 0);
    check("R4", "half of -3 rounds up", rnd(-64'sd24576), -1);

    // R2, R3, R5: sweep pairs including saturating extremes.
    for (int k = 0; k < 7; k++) begin
      load(cset[k], dset[k]);
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++) step(1, vals[i], vals[j], 0, 0, 0, 0, "R2/R3/R5");
      idle(4);
    end

    // R11: write and commit together; commit takes the pre-write shadow.
    load(16384, 0);
    step(0, 0, 0, 1, 0, 4096, 1, "R11");
    step(1, 5000, -7000, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 1, "R11");
    step(1, 5000, -7000, 0, 0, 0, 0, "R11");
    idle(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule